// File: doc/BRIEF.md
# Binary Point Register Bank with Access Aliasing

This block keeps the three 3-bit binary point values of an interrupt CPU interface: one for group 0, one for secure group 1 and one for non-secure group 1. Software reaches them through two register addresses. The first address always selects the group 0 value. The second address is the group 1 view. Which stored value it reaches depends on context inputs that come with each access: the security state, whether the accessor runs at the monitor level, the current exception level, and two common-binary-point control bits. One of these bits comes from the secure control register and the other from the non-secure control register.

When the common-binary-point bit is set, a secure group 1 access from outside the monitor is redirected to the group 0 value. A non-secure group 1 access from below exception level 3 with its common bit set sees the group 0 value plus one, saturated at 7, and cannot write. Reads complete one cycle after the access. Each write that changes state raises a one-cycle update pulse. All three stored values are also driven out continuously, for use by the priority grouping logic that sits outside this block.

Top module: `bpr_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, group 0 and secure group 1 load `MIN_BPR` (default 0). Non-secure group 1 loads `MIN_BPR_NS` (default 1) when `cfg_has_monitor` is 1, and `MIN_BPR` otherwise. After reset, `rd_valid` and `upd_pulse` are 0.
- R2: An access with `acc_bpr1`=0 reads or writes the group 0 value in every context.
- R3: An access with `acc_bpr1`=1 and `ctx_sec_below_mon`=0 reaches the non-secure group 1 value, unless R6 applies.
- R4: An access with `acc_bpr1`=1 and `ctx_sec_below_mon`=1 reaches the secure group 1 value, unless R5 applies.
- R5: An R4-type access with `ctx_at_monitor`=0 and `ctl_s_cbp`=1 reads and writes the group 0 value instead.
- R6: An R3-type access with `ctx_el`≠3 and `ctl_ns_cbp`=1 reads as min(group 0 value + 1, 7).
- R7: A write under the R6 condition changes no stored value and raises no update pulse.
- R8: A write stores only bits [2:0] of `acc_wdata`. Bits above bit 2 of `rd_data` always read as zero.
- R9: A read access (`acc_valid`=1, `acc_write`=0) sets `rd_valid` to 1 with its data in the following cycle. An accepted write sets `upd_pulse` to 1 for exactly the following cycle.
- R10: A write changes only the value it is routed to. The other two values keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_has_monitor | input | 1 | A monitor level exists (selects the non-secure group 1 reset value) |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_bpr1 | input | 1 | 0 = group 0 address, 1 = group 1 address |
| acc_wdata | input | DATA_W | Write data |
| ctx_sec_below_mon | input | 1 | Accessor is secure and below the monitor level |
| ctx_at_monitor | input | 1 | Accessor runs at the monitor level |
| ctx_el | input | 2 | Current exception level |
| ctl_s_cbp | input | 1 | Common-binary-point bit of the secure control register |
| ctl_ns_cbp | input | 1 | Common-binary-point bit of the non-secure control register |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data, zero above the value width |
| upd_pulse | output | 1 | One-cycle pulse after an accepted write |
| bpr_g0_o | output | BPR_W | Current group 0 value |
| bpr_g1s_o | output | BPR_W | Current secure group 1 value |
| bpr_g1ns_o | output | BPR_W | Current non-secure group 1 value |

## Verification
The bench sweeps all 128 combinations of address and context bits, and runs every 3-bit value through a write and a read-back in each one. This exposes a routing table that mixes up the two redirect rules: for example, one that applies the secure redirect at the monitor level, or the non-secure one at exception level 3, would write the wrong bank. Saturation is aimed at group 0 values of 6 and 7. A design that drops the clamp reads 0 instead of 7. A design that lets the blocked non-secure write through corrupts group 0 and pulses the strobe. Both reset configurations are checked, so a fixed non-secure reset value is caught. Junk in the upper write-data bits catches any failure to mask on write or zero-fill on read.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2
  } grp_e;

  localparam int NUM_GRP = 3;

  typedef struct packed {
    grp_e grp;        // bank actually reached
    logic s_redir;    // secure group 1 folded onto group 0
    logic ns_common;  // non-secure common view: read +1, write dropped
  } route_t;

  // Steer one access to a bank from address and context.
  function automatic route_t route_access(
    input logic       bpr1,
    input logic       sec_below,
    input logic       at_mon,
    input logic [1:0] el,
    input logic       s_cbp,
    input logic       ns_cbp
  );
    route_t r;
    r.grp       = GRP_G0;
    r.s_redir   = 1'b0;
    r.ns_common = 1'b0;
    if (bpr1) begin
      r.grp = sec_below ? GRP_G1S : GRP_G1NS;
      if (r.grp == GRP_G1S && !at_mon && s_cbp) begin
        r.grp     = GRP_G0;
        r.s_redir = 1'b1;
      end else if (r.grp == GRP_G1NS && el != 2'd3 && ns_cbp) begin
        r.grp       = GRP_G0;
        r.ns_common = 1'b1;
      end
    end
    return r;
  endfunction

  // Increment by one, clamped at top.
  function automatic logic [7:0] sat_inc(input logic [7:0] v, input logic [7:0] top);
    return (v >= top) ? top : v + 8'd1;
  endfunction

endpackage

// File: rtl/bpr_route.sv
module bpr_route
  import bpr_pkg::*;
(
  input  logic       bpr1,
  input  logic       sec_below,
  input  logic       at_mon,
  input  logic [1:0] el,
  input  logic       s_cbp,
  input  logic       ns_cbp,
  output grp_e       grp,
  output logic       s_redir,
  output logic       ns_common
);
  route_t r;

  always_comb begin
    r         = route_access(bpr1, sec_below, at_mon, el, s_cbp, ns_cbp);
    grp       = r.grp;
    s_redir   = r.s_redir;
    ns_common = r.ns_common;
  end
endmodule

// File: rtl/bpr_store.sv
module bpr_store
  import bpr_pkg::*;
#(
  parameter int BPR_W      = 3,
  parameter int MIN_BPR    = 0,
  parameter int MIN_BPR_NS = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_has_monitor,
  input  logic                              wr_en,
  input  grp_e                              wr_grp,
  input  logic [BPR_W-1:0]                  wr_val,
  output logic [NUM_GRP-1:0][BPR_W-1:0]     vals
);
  localparam logic [BPR_W-1:0] RST_MIN = BPR_W'(MIN_BPR);
  localparam logic [BPR_W-1:0] RST_NS  = BPR_W'(MIN_BPR_NS);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
    logic [BPR_W-1:0] rst_val;
    if (g == int'(GRP_G1NS)) begin : g_ns
      assign rst_val = cfg_has_monitor ? RST_NS : RST_MIN;
    end else begin : g_plain
      assign rst_val = RST_MIN;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vals[g] <= rst_val;
      end else if (wr_en && wr_grp == grp_e'(g)) begin
        vals[g] <= wr_val;
      end
    end
  end
endmodule

// File: rtl/bpr_readout.sv
module bpr_readout
  import bpr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BPR_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  grp_e                          rd_grp,
  input  logic                          rd_sat,
  input  logic [NUM_GRP-1:0][BPR_W-1:0] vals,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data
);
  localparam int SAT_MAX = (1 << BPR_W) - 1;

  logic [BPR_W-1:0] raw;
  logic [BPR_W-1:0] view;

  always_comb begin
    case (rd_grp)
      GRP_G1S:  raw = vals[1];
      GRP_G1NS: raw = vals[2];
      default:  raw = vals[0];
    endcase
    view = rd_sat ? BPR_W'(sat_inc(8'(raw), 8'(SAT_MAX))) : raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data              <= '0;
        rd_data[BPR_W-1:0]   <= view;
      end
    end
  end
endmodule

// File: rtl/bpr_bank.sv
module bpr_bank
  import bpr_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BPR_W      = 3,
  parameter int MIN_BPR    = 0,
  parameter int MIN_BPR_NS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_has_monitor,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_bpr1,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              ctx_sec_below_mon,
  input  logic              ctx_at_monitor,
  input  logic [1:0]        ctx_el,
  input  logic              ctl_s_cbp,
  input  logic              ctl_ns_cbp,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              upd_pulse,
  output logic [BPR_W-1:0]  bpr_g0_o,
  output logic [BPR_W-1:0]  bpr_g1s_o,
  output logic [BPR_W-1:0]  bpr_g1ns_o
);
  // Named internal events for the checker
  grp_e                          tgt_grp;
  logic                          ev_s_redir;
  logic                          ev_ns_common;
  logic                          ev_wr_accept;
  logic                          ev_rd;
  logic [NUM_GRP-1:0][BPR_W-1:0] vals;
  logic                          unused_wdata_hi;

  assign unused_wdata_hi = ^acc_wdata[DATA_W-1:BPR_W];

  bpr_route u_route (
    .bpr1      (acc_bpr1),
    .sec_below (ctx_sec_below_mon),
    .at_mon    (ctx_at_monitor),
    .el        (ctx_el),
    .s_cbp     (ctl_s_cbp),
    .ns_cbp    (ctl_ns_cbp),
    .grp       (tgt_grp),
    .s_redir   (ev_s_redir),
    .ns_common (ev_ns_common)
  );

  assign ev_wr_accept = acc_valid && acc_write && !ev_ns_common;
  assign ev_rd        = acc_valid && !acc_write;

  bpr_store #(
    .BPR_W      (BPR_W),
    .MIN_BPR    (MIN_BPR),
    .MIN_BPR_NS (MIN_BPR_NS)
  ) u_store (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_has_monitor (cfg_has_monitor),
    .wr_en           (ev_wr_accept),
    .wr_grp          (tgt_grp),
    .wr_val          (acc_wdata[BPR_W-1:0]),
    .vals            (vals)
  );

  bpr_readout #(
    .DATA_W (DATA_W),
    .BPR_W  (BPR_W)
  ) u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (ev_rd),
    .rd_grp   (tgt_grp),
    .rd_sat   (ev_ns_common),
    .vals     (vals),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) upd_pulse <= 1'b0;
    else        upd_pulse <= ev_wr_accept;
  end

  assign bpr_g0_o   = vals[0];
  assign bpr_g1s_o  = vals[1];
  assign bpr_g1ns_o = vals[2];
endmodule

// File: rtl/bpr_bank_chk.sv
module bpr_bank_chk
  import bpr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BPR_W   = 3,
  parameter int MIN_BPR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              upd_pulse,
  input logic [BPR_W-1:0]  bpr_g0_o,
  input logic [BPR_W-1:0]  bpr_g1s_o,
  input logic [BPR_W-1:0]  bpr_g1ns_o,
  input grp_e              tgt_grp,
  input logic              ev_s_redir,
  input logic              ev_ns_common
);
  p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bpr_g0_o == BPR_W'(MIN_BPR) && bpr_g1s_o == BPR_W'(MIN_BPR)));

  p_redirect_keeps_s_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && ev_s_redir) |=> $stable(bpr_g1s_o));

  p_sat_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && ev_ns_common) |=> (rd_data != '0));

  p_blocked_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && ev_ns_common) |=>
      (!upd_pulse && $stable(bpr_g0_o) && $stable(bpr_g1s_o) && $stable(bpr_g1ns_o)));

  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[DATA_W-1:BPR_W] == '0));

  p_rd_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);

  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> $past(acc_valid && acc_write));

  p_ns_untouched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && tgt_grp != GRP_G1NS) |=> $stable(bpr_g1ns_o));
endmodule

bind bpr_bank bpr_bank_chk #(
  .DATA_W  (DATA_W),
  .BPR_W   (BPR_W),
  .MIN_BPR (MIN_BPR)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .upd_pulse    (upd_pulse),
  .bpr_g0_o     (bpr_g0_o),
  .bpr_g1s_o    (bpr_g1s_o),
  .bpr_g1ns_o   (bpr_g1ns_o),
  .tgt_grp      (tgt_grp),
  .ev_s_redir   (ev_s_redir),
  .ev_ns_common (ev_ns_common)
);

// File: tb/test_bpr_bank.sv
`timescale 1ns/1ps
module test_bpr_bank;
  localparam int DATA_W = 8;
  localparam int BPR_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_has_monitor;
  logic              acc_valid, acc_write, acc_bpr1;
  logic [DATA_W-1:0] acc_wdata;
  logic              ctx_sec_below_mon, ctx_at_monitor;
  logic [1:0]        ctx_el;
  logic              ctl_s_cbp, ctl_ns_cbp;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic              upd_pulse;
  logic [BPR_W-1:0]  bpr_g0_o, bpr_g1s_o, bpr_g1ns_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // model state
  int m_bank[3];

  always #2 clk = ~clk;

  bpr_bank i_bpr_bank (
    .clk(clk), .rst_n(rst_n), .cfg_has_monitor(cfg_has_monitor),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_bpr1(acc_bpr1),
    .acc_wdata(acc_wdata), .ctx_sec_below_mon(ctx_sec_below_mon),
    .ctx_at_monitor(ctx_at_monitor), .ctx_el(ctx_el),
    .ctl_s_cbp(ctl_s_cbp), .ctl_ns_cbp(ctl_ns_cbp),
    .rd_valid(rd_valid), .rd_data(rd_data), .upd_pulse(upd_pulse),
    .bpr_g0_o(bpr_g0_o), .bpr_g1s_o(bpr_g1s_o), .bpr_g1ns_o(bpr_g1ns_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bank index the model expects: 0 = group 0, 1 = secure g1, 2 = ns g1.
  // common = 1 means the non-secure common view (read +1 clamp, write dropped).
  function automatic int model_bank(input bit b1, input bit sb, input bit mon,
                                    input int el, input bit scb, input bit nscb,
                                    output bit common);
    common = 0;
    if (!b1) return 0;                          // R2
    if (sb) return (!mon && scb) ? 0 : 1;       // R4, R5
    if (nscb && el < 3) begin common = 1; return 0; end  // R6
    return 2;                                   // R3
  endfunction

  task automatic set_ctx(input bit b1, input bit sb, input bit mon,
                         input int el, input bit scb, input bit nscb);
    acc_bpr1 = b1; ctx_sec_below_mon = sb; ctx_at_monitor = mon;
    ctx_el = 2'(el); ctl_s_cbp = scb; ctl_ns_cbp = nscb;
  endtask

  task automatic do_reset(input bit has_mon);
    @(negedge clk);
    cfg_has_monitor = has_mon; rst_n = 1'b0; acc_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_bank[0] = 0; m_bank[1] = 0; m_bank[2] = has_mon ? 1 : 0;
    check(bpr_g0_o == 0, "R1 g0 reset", bpr_g0_o, 0);
    check(bpr_g1s_o == 0, "R1 g1s reset", bpr_g1s_o, 0);
    check(int'(bpr_g1ns_o) == m_bank[2], "R1 g1ns reset", bpr_g1ns_o, m_bank[2]);
    check(!rd_valid && !upd_pulse, "R1 outputs idle", {rd_valid, upd_pulse}, 0);
  endtask

  task automatic do_write(input int val, input int hi, input string tag);
    bit common;
    int b, exp_v;
    b = model_bank(acc_bpr1, ctx_sec_below_mon, ctx_at_monitor, int'(ctx_el),
                   ctl_s_cbp, ctl_ns_cbp, common);
    acc_wdata = DATA_W'((hi << BPR_W) | val);
    acc_write = 1'b1; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    if (!common) m_bank[b] = val % 8;           // R8 masking
    check(upd_pulse == !common, {tag, " R9/R7 pulse"}, upd_pulse, !common);
    check(int'(bpr_g0_o) == m_bank[0], {tag, " R10 g0"}, bpr_g0_o, m_bank[0]);
    check(int'(bpr_g1s_o) == m_bank[1], {tag, " R10 g1s"}, bpr_g1s_o, m_bank[1]);
    check(int'(bpr_g1ns_o) == m_bank[2], {tag, " R10 g1ns"}, bpr_g1ns_o, m_bank[2]);
    exp_v = 0;
  endtask

  task automatic do_read(input string tag);
    bit common;
    int b, exp_v;
    b = model_bank(acc_bpr1, ctx_sec_below_mon, ctx_at_monitor, int'(ctx_el),
                   ctl_s_cbp, ctl_ns_cbp, common);
    exp_v = m_bank[b];
    if (common) exp_v = (exp_v + 1 > 7) ? 7 : exp_v + 1;  // R6
    acc_write = 1'b0; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    check(rd_valid == 1'b1, {tag, " R9 rd_valid"}, rd_valid, 1);
    check(int'(rd_data) == exp_v, {tag, " R8 read data"}, rd_data, exp_v);
    @(negedge clk);
    check(rd_valid == 1'b0 && upd_pulse == 1'b0, {tag, " R9 single cycle"},
          {rd_valid, upd_pulse}, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_has_monitor = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    acc_wdata = '0;
    set_ctx(0, 0, 0, 0, 0, 0);

    do_reset(1'b1);
    do_reset(1'b0);

    // Sweep every context combination with every value.
    for (int c = 0; c < 128; c++) begin
      set_ctx(c[0], c[1], c[2], (c >> 3) & 3, c[5], c[6]);
      for (int v = 0; v < 8; v++) begin
        do_write(v, (c + v) % 32, "sweep R2/R3/R4/R5");
        do_read("sweep R6");
      end
    end

    // Directed saturation: group 0 at 7, 6, 3 seen through ns common view.
    set_ctx(0, 0, 0, 1, 0, 0); do_write(7, 31, "R6 setup");
    set_ctx(1, 0, 0, 1, 0, 1); do_read("R6 sat at 7");
    do_write(2, 0, "R7 blocked");
    set_ctx(0, 0, 0, 0, 0, 0); do_write(6, 0, "R6 setup");
    set_ctx(1, 0, 0, 2, 0, 1); do_read("R6 6 to 7");
    set_ctx(0, 0, 0, 0, 0, 0); do_write(3, 21, "R6 setup");
    set_ctx(1, 0, 0, 0, 0, 1); do_read("R6 3 to 4");
    // EL3 non-secure with common bit reaches ns bank directly.
    set_ctx(1, 0, 0, 3, 0, 1); do_write(5, 0, "R3 el3");
    do_read("R3 el3 read");
    // Monitor access ignores secure common bit.
    set_ctx(1, 1, 1, 3, 1, 0); do_write(4, 7, "R5 monitor");
    do_read("R4 monitor read");

    // Reset after traffic restores defaults.
    do_reset(1'b1);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule